// File: doc/BRIEF.md
# Core Event Priority Controller

This block arbitrates sixteen ordered event slots for a processor core and reports the single event the core should take next, as a slot index. Slot 0 is the most urgent. The slots are assigned as follows: slot 0 emulation, slot 1 reset, slot 2 non-maskable interrupt, slot 3 exception, slot 4 unused (held inert), slot 5 hardware error, slot 6 core timer, and slots 7 to 15 general-purpose levels 7 to 15. Levels 7 to 13 take peripheral requests. Levels 14 and 15 are kept for interrupts that software raises itself.

Each slot keeps a sticky pending flag. The maskable slots also carry an enable bit. A set of in-service flags records how deeply the handlers are nested. The core acknowledges the presented event to enter its handler and pulses a return strobe when it leaves the handler. An event is offered only when it outranks everything already in service, so a handler can be interrupted only by something more urgent.

Top module: `core_evt_prio`

## Requirements
- R1: After reset, every pending flag, in-service flag and enable bit is clear, and `evtValid` is 0.
- R2: A high `evtReq[i]` at a clock edge sets pending flag i. The flag stays set until that slot is acknowledged.
- R3: Slot 4 never becomes pending, in service or presented, whatever `evtReq[4]` does.
- R4: Slots 0 to 3 are always eligible. Slots 5 to 15 are eligible only while their enable bit is set. A write with `maskWr` high loads enable bits 5 to 15 from `maskData[5..15]` at the clock edge. `maskData[0..4]` are ignored.
- R5: Among pending, eligible slots, the lowest index is the one presented on `evtIdx`.
- R6: `evtValid` is 1 only when the candidate index is strictly lower than the lowest in-service index, or when nothing is in service. An equal or higher index waits.
- R7: `ack` while `evtValid` is 1 clears the pending flag of the presented slot and sets its in-service flag at the edge. `ack` while `evtValid` is 0 changes nothing.
- R8: `rti` clears the lowest-index in-service flag at the edge. When nothing is in service, `rti` changes nothing.
- R9: `swRaise[0]` sets pending flag 14, and `swRaise[1]` sets pending flag 15.
- R10: When a request for slot i arrives in the same cycle that slot i is acknowledged, pending flag i stays set and the in-service flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtReq | input | 16 | Request per slot, one bit per slot index |
| swRaise | input | 2 | Software raise for levels 14 (bit 0) and 15 (bit 1) |
| maskWr | input | 1 | Load enable bits from `maskData` |
| maskData | input | 16 | New enable bits, one per slot |
| ack | input | 1 | Core accepts the presented event |
| rti | input | 1 | Core returns from the innermost handler |
| evtValid | output | 1 | An event is offered to the core |
| evtIdx | output | 4 | Slot index of the offered event |
| pendingOut | output | 16 | Current pending flags |
| activeOut | output | 16 | Current in-service flags |

## Verification
The bench builds the block with its default parameters: sixteen slots, the inert slot at index 4, four always-eligible top slots and two software-raised levels. With sixteen slots, a behavioural model can follow every pending, enable and nesting bit cycle by cycle. A few thousand biased random cycles then reach deep nesting, preemption by the unmaskable slots and return with nothing left in service. Directed steps cover the inert slot, enable gating, software raise and the collision between a request and an acknowledge of the same slot.

// File: rtl/core_evt_prio_pkg.sv
package core_evt_prio_pkg;
  localparam int EVT_CNT = 16;
  localparam int IDX_W = $clog2(EVT_CNT);

  typedef logic [IDX_W-1:0] evtIdx_t;
  typedef logic [EVT_CNT-1:0] evtVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    ackEn;
    evtIdx_t ackIdx;
    logic    rtiEn;
    evtIdx_t rtiIdx;
  } ctrlStrb_t;

  // lowest set index wins; flag reports any set bit
  function automatic evtIdx_t firstSet(input evtVec_t v);
    evtIdx_t r;
    r = '0;
    for (int i = EVT_CNT - 1; i >= 0; i--) begin
      if (v[i]) r = evtIdx_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/core_evt_prio_dp.sv
module core_evt_prio_dp
  import core_evt_prio_pkg::*;
#(
  parameter int RSV_SLOT  = 4,
  parameter int NUM_FIXED = 4,
  parameter int NUM_SW    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtVec_t           evtReq,
  input  logic [NUM_SW-1:0] swRaise,
  input  logic              maskWr,
  input  evtVec_t           maskData,
  input  ctrlStrb_t         strb,
  output logic              candValid,
  output evtIdx_t           candIdx,
  output logic              isrValid,
  output evtIdx_t           isrTop,
  output evtVec_t           pendQ,
  output evtVec_t           isrQ
);
  localparam int SW_BASE = EVT_CNT - NUM_SW;

  evtVec_t maskQ;
  evtVec_t fixedEn;
  evtVec_t maskable;
  evtVec_t swVec;
  evtVec_t setVec;
  evtVec_t ackClr;
  evtVec_t ackSet;
  evtVec_t rtiClr;
  evtVec_t eligible;

  for (genvar g = 0; g < EVT_CNT; g++) begin : g_slotCls
    assign fixedEn[g]  = (g < NUM_FIXED) && (g != RSV_SLOT);
    assign maskable[g] = (g >= NUM_FIXED) && (g != RSV_SLOT);
    if (g >= SW_BASE) begin : g_sw
      assign swVec[g] = swRaise[g - SW_BASE];
    end else begin : g_nosw
      assign swVec[g] = 1'b0;
    end
  end

  always_comb begin
    setVec = (evtReq | swVec) & (fixedEn | maskable);
    ackClr = '0;
    ackSet = '0;
    rtiClr = '0;
    if (strb.ackEn) begin
      ackClr[strb.ackIdx] = 1'b1;
      ackSet[strb.ackIdx] = 1'b1;
    end
    if (strb.rtiEn) rtiClr[strb.rtiIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      isrQ  <= '0;
      maskQ <= '0;
    end else begin
      pendQ <= (pendQ & ~ackClr) | setVec;
      isrQ  <= (isrQ & ~rtiClr) | ackSet;
      if (maskWr) maskQ <= maskData & maskable;
    end
  end

  always_comb begin
    eligible  = pendQ & (fixedEn | maskQ);
    candValid = |eligible;
    candIdx   = firstSet(eligible);
    isrValid  = |isrQ;
    isrTop    = firstSet(isrQ);
  end

  for (genvar g = 0; g < EVT_CNT; g++) begin : g_pendChk
    // R2
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[g] && !(strb.ackEn && strb.ackIdx == evtIdx_t'(g))) |=> pendQ[g]);
  end

  // R7
  ack_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackEn |=> isrQ[$past(strb.ackIdx)]);

  // R8
  rti_leave_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rtiEn |=> !isrQ[$past(strb.rtiIdx)]);

  // R3
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendQ[RSV_SLOT] && !isrQ[RSV_SLOT]);
endmodule

// File: rtl/core_evt_prio_ctrl.sv
module core_evt_prio_ctrl
  import core_evt_prio_pkg::*;
#(
  parameter int RSV_SLOT = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      candValid,
  input  evtIdx_t   candIdx,
  input  logic      isrValid,
  input  evtIdx_t   isrTop,
  input  logic      ack,
  input  logic      rti,
  output logic      evtValid,
  output evtIdx_t   evtIdx,
  output ctrlStrb_t strb
);
  always_comb begin
    evtValid    = candValid && (!isrValid || (candIdx < isrTop));
    evtIdx      = candIdx;
    strb.ackEn  = ack && evtValid;
    strb.ackIdx = candIdx;
    strb.rtiEn  = rti && isrValid;
    strb.rtiIdx = isrTop;
  end

  // R6
  strict_preempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && isrValid) |-> (evtIdx < isrTop));

  // R3
  rsv_never_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtIdx != evtIdx_t'(RSV_SLOT)));

  // R7
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid |-> !strb.ackEn);
endmodule

// File: rtl/core_evt_prio.sv
module core_evt_prio
  import core_evt_prio_pkg::*;
#(
  parameter int RSV_SLOT  = 4,
  parameter int NUM_FIXED = 4,
  parameter int NUM_SW    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [EVT_CNT-1:0]  evtReq,
  input  logic [NUM_SW-1:0]   swRaise,
  input  logic                maskWr,
  input  logic [EVT_CNT-1:0]  maskData,
  input  logic                ack,
  input  logic                rti,
  output logic                evtValid,
  output logic [IDX_W-1:0]    evtIdx,
  output logic [EVT_CNT-1:0]  pendingOut,
  output logic [EVT_CNT-1:0]  activeOut
);
  ctrlStrb_t strb;
  logic      candValid;
  evtIdx_t   candIdx;
  logic      isrValid;
  evtIdx_t   isrTop;

  core_evt_prio_dp #(
    .RSV_SLOT (RSV_SLOT),
    .NUM_FIXED(NUM_FIXED),
    .NUM_SW   (NUM_SW)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .evtReq   (evtReq),
    .swRaise  (swRaise),
    .maskWr   (maskWr),
    .maskData (maskData),
    .strb     (strb),
    .candValid(candValid),
    .candIdx  (candIdx),
    .isrValid (isrValid),
    .isrTop   (isrTop),
    .pendQ    (pendingOut),
    .isrQ     (activeOut)
  );

  core_evt_prio_ctrl #(
    .RSV_SLOT(RSV_SLOT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .candValid(candValid),
    .candIdx  (candIdx),
    .isrValid (isrValid),
    .isrTop   (isrTop),
    .ack      (ack),
    .rti      (rti),
    .evtValid (evtValid),
    .evtIdx   (evtIdx),
    .strb     (strb)
  );
endmodule

// File: tb/core_evt_prio_tb_top.sv
`timescale 1ns/1ps
module core_evt_prio_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] evtReq = '0;
  logic [1:0]  swRaise = '0;
  logic        maskWr = 1'b0;
  logic [15:0] maskData = '0;
  logic        ack = 1'b0;
  logic        rti = 1'b0;
  logic        evtValid;
  logic [3:0]  evtIdx;
  logic [15:0] pendingOut;
  logic [15:0] activeOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  bit mPend[16];
  bit mMask[16];
  bit mIsr[16];

  always #2 clk = ~clk;

  core_evt_prio dut_i (
    .clk(clk), .rstN(rstN), .evtReq(evtReq), .swRaise(swRaise),
    .maskWr(maskWr), .maskData(maskData), .ack(ack), .rti(rti),
    .evtValid(evtValid), .evtIdx(evtIdx),
    .pendingOut(pendingOut), .activeOut(activeOut)
  );

  function automatic bit eligibleSlot(int i);
    if (i == 4) return 0;
    if (i < 4) return 1;
    return mMask[i];
  endfunction

  function automatic int modelCand();
    for (int i = 0; i < 16; i++) if (mPend[i] && eligibleSlot(i)) return i;
    return 16;
  endfunction

  function automatic int modelTop();
    for (int i = 0; i < 16; i++) if (mIsr[i]) return i;
    return 16;
  endfunction

  function automatic bit modelValid();
    int c;
    c = modelCand();
    return (c < 16) && (c < modelTop());
  endfunction

  function automatic logic [15:0] packBits(bit v[16]);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[i];
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit v;
    v = modelValid();
    check("R6 evtValid", int'(evtValid), int'(v));
    if (v) check("R5 evtIdx", int'(evtIdx), modelCand());
    check("R2 pending", int'(pendingOut), int'(packBits(mPend)));
    check("R7/R8 active", int'(activeOut), int'(packBits(mIsr)));
  endtask

  // advance one cycle with the inputs currently driven, update model, compare
  task automatic step();
    bit doAck, doRti;
    int c, t;
    @(posedge clk);
    c = modelCand();
    t = modelTop();
    doAck = ack && modelValid();
    doRti = rti && (t < 16);
    if (doAck) mPend[c] = 0;
    for (int i = 0; i < 16; i++) if (evtReq[i] && i != 4) mPend[i] = 1;
    if (swRaise[0]) mPend[14] = 1;
    if (swRaise[1]) mPend[15] = 1;
    if (maskWr) for (int i = 0; i < 16; i++) mMask[i] = (i > 4) ? maskData[i] : 1'b0;
    if (doRti) mIsr[t] = 0;
    if (doAck) mIsr[c] = 1;
    @(negedge clk);
    compareAll();
  endtask

  task automatic drive(logic [15:0] r, logic [1:0] s, logic mw, logic [15:0] md,
                       logic a, logic x);
    evtReq = r; swRaise = s; maskWr = mw; maskData = md; ack = a; rti = x;
  endtask

  task automatic idle();
    drive('0, '0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mPend[i] = 0; mMask[i] = 0; mIsr[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1
    check("R1 evtValid", int'(evtValid), 0);
    check("R1 pending", int'(pendingOut), 0);
    check("R1 active", int'(activeOut), 0);

    // R3: inert slot
    drive(16'h0010, '0, 1'b0, '0, 1'b0, 1'b0); step();
    check("R3 slot4 pending", int'(pendingOut[4]), 0);
    check("R3 no event", int'(evtValid), 0);
    drive('0, '0, 1'b0, '0, 1'b1, 1'b0); step();
    check("R3 active clear", int'(activeOut), 0);

    // R4: masked timer request waits until enabled
    drive(16'h0040, '0, 1'b0, '0, 1'b0, 1'b0); step();
    check("R4 masked wait", int'(evtValid), 0);
    check("R2 sticky", int'(pendingOut[6]), 1);
    drive('0, '0, 1'b1, 16'h001F, 1'b0, 1'b0); step();
    check("R4 low mask bits ignored", int'(evtValid), 0);
    drive('0, '0, 1'b1, 16'h0040, 1'b0, 1'b0); step();
    check("R4 enabled valid", int'(evtValid), 1);
    check("R4 enabled idx", int'(evtIdx), 6);

    // R7: ack enters timer handler
    drive('0, '0, 1'b0, '0, 1'b1, 1'b0); step();
    check("R7 active6", int'(activeOut[6]), 1);
    check("R7 pend6 clr", int'(pendingOut[6]), 0);

    // R9 + R6: software level waits behind timer
    drive('0, 2'b10, 1'b1, 16'hFFE0, 1'b0, 1'b0); step();
    check("R9 sw15", int'(pendingOut[15]), 1);
    check("R6 lower waits", int'(evtValid), 0);
    // R5/R6: exception preempts
    drive(16'h0008, 2'b01, 1'b0, '0, 1'b0, 1'b0); step();
    check("R9 sw14", int'(pendingOut[14]), 1);
    check("R6 preempt idx", int'(evtIdx), 3);
    drive('0, '0, 1'b0, '0, 1'b1, 1'b0); step();
    // R6: same slot again waits
    drive(16'h0008, '0, 1'b0, '0, 1'b0, 1'b0); step();
    check("R6 equal waits", int'(evtValid), 0);
    // R8
    drive('0, '0, 1'b0, '0, 1'b0, 1'b1); step();
    check("R8 innermost clr", int'(activeOut), 16'h0040);
    check("R6 reoffer", int'(evtIdx), 3);
    // R10: request same slot as ack
    drive(16'h0008, '0, 1'b0, '0, 1'b1, 1'b0); step();
    check("R10 pend kept", int'(pendingOut[3]), 1);
    check("R10 active set", int'(activeOut[3]), 1);
    // drain
    for (int k = 0; k < 8; k++) begin drive('0, '0, 1'b0, '0, 1'b0, 1'b1); step(); end
    for (int k = 0; k < 8; k++) begin drive('0, '0, 1'b0, '0, 1'b1, 1'b0); step(); end
    for (int k = 0; k < 8; k++) begin drive('0, '0, 1'b0, '0, 1'b0, 1'b1); step(); end
    check("R8 empty", int'(activeOut), 0);
    drive('0, '0, 1'b0, '0, 1'b0, 1'b1); step();
    check("R8 rti idle", int'(activeOut), 0);

    // random phase, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] r;
      r = '0;
      for (int i = 0; i < 16; i++) begin
        if (i < 4) r[i] = ($urandom_range(0, 99) < 2);
        else r[i] = ($urandom_range(0, 99) < 6);
      end
      drive(r, 2'($urandom_range(0, 99) < 5 ? $urandom_range(1, 3) : 0),
            1'($urandom_range(0, 99) < 4), 16'($urandom),
            1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0));
      step();
    end
    idle();
    step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule